// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Compare Event

This block is a memory-mapped timer built around a 64-bit up-counter that advances once per clock while enabled. A 64-bit compare value is checked against the counter every cycle. When the comparator is enabled and the two are equal, a sticky event flag is raised. The flag drives a level interrupt whenever the interrupt enable is set. An optional auto-increment mode adds a programmed 32-bit step to the compare value on every match. Periodic events then keep running without software re-arming them.

Software reaches the block over a plain 32-bit register port: address, write enable, write data and a combinational read data. The counter is exposed as two halves that are not latched. A reader therefore reads high, low, then high again, and retries if the two high reads differ. For this to work, the high half changes in the same cycle that the low half wraps. The counter halves may be loaded only while counting is stopped, which lets software zero the count before starting it.

Top module: `gtmr_top`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_o` is low.
- R2: Register map (byte offsets):
  - 0x00: count bits 31:0
  - 0x04: count bits 63:32
  - 0x08: control
  - 0x0C: status
  - 0x10: compare bits 31:0
  - 0x14: compare bits 63:32
  - 0x18: increment step
  
  The compare halves and the step read back as written. Control keeps only bits 3:0 and reads zero above them. Any other offset reads zero.
- R3: While control bit 0 (run) is 1, the count rises by exactly one per clock. While run is 0, the count holds.
- R4: A write to either count half takes effect only while run is 0. Such writes made while run is 1 are ignored.
- R5: The count high half increments in the same clock edge on which the low half wraps from all ones to zero.
- R6: When control bit 1 (compare enable) is 1 and the count equals the 64-bit compare value, status bit 0 (event) reads 1 from the next cycle on. With compare enable at 0, the event flag is never set.
- R7: The event flag stays set until a write to status with bit 0 at 1 clears it. A write to status with bit 0 at 0 leaves it set.
- R8: When control bit 3 (auto-increment) is 1, each match adds the step register, zero-extended, to the full 64-bit compare value on the same edge that sets the flag. The carry propagates into the high half.
- R9: `irq_o` is high exactly when the event flag is set and control bit 2 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one register write per asserted cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the block's inputs:
- The write strobe and address are known (never X) outside reset.
- A compare write and a match landing on the same edge resolve in favour of the write. The auto-increment property is therefore only claimed on cycles with no compare write.

The stimulus keeps to these assumptions:
- It drives one full-word access per cycle, always at an aligned offset, on the falling edge.
- It never writes a compare half during a cycle in which a match can occur.
- It loads the counter only after a cycle that has stopped it.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    // Register byte offsets; software drivers decode these, so they are fixed.
    localparam int OFS_CNT_LO = 'h00;
    localparam int OFS_CNT_HI = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_STAT   = 'h0C;
    localparam int OFS_CMP_LO = 'h10;
    localparam int OFS_CMP_HI = 'h14;
    localparam int OFS_STEP   = 'h18;

    localparam int CTRL_W = 4;

    // Field order matches control bits 3..0.
    typedef struct packed {
        logic auto_inc;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic ctrl;
        logic stat;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
    } wr_strobe_t;

    function automatic ctrl_t ctrl_from_word(input logic [CTRL_W-1:0] bits);
        return ctrl_t'(bits);
    endfunction

endpackage

// File: rtl/gtmr_regif.sv
module gtmr_regif
    import gtmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 32
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2*DW-1:0]   cnt,
    input  ctrl_t             ctrl,
    input  logic              flag,
    input  logic [2*DW-1:0]   cmp,
    input  logic [DW-1:0]     step,
    output wr_strobe_t        wr,
    output logic [DW-1:0]     rdata
);
    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFS_CMP_LO);
    localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFS_CMP_HI);
    localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(OFS_STEP);

    always_comb begin
        wr.cnt_lo = we && (addr == A_CNT_LO);
        wr.cnt_hi = we && (addr == A_CNT_HI);
        wr.ctrl   = we && (addr == A_CTRL);
        wr.stat   = we && (addr == A_STAT);
        wr.cmp_lo = we && (addr == A_CMP_LO);
        wr.cmp_hi = we && (addr == A_CMP_HI);
        wr.step   = we && (addr == A_STEP);
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CNT_LO: rdata = cnt[DW-1:0];
            A_CNT_HI: rdata = cnt[2*DW-1:DW];
            A_CTRL:   rdata = DW'(ctrl);
            A_STAT:   rdata = DW'(flag);
            A_CMP_LO: rdata = cmp[DW-1:0];
            A_CMP_HI: rdata = cmp[2*DW-1:DW];
            A_STEP:   rdata = step;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt
);
    localparam int CW = 2 * DW;

    logic [DW-1:0] lo_q, hi_q;
    logic          lo_wrap;

    assign lo_wrap = &lo_q;
    assign cnt     = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (run) begin
            lo_q <= lo_q + 1'b1;
            if (lo_wrap) hi_q <= hi_q + 1'b1;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));

    p_count_r3: assert property (@(posedge clk) disable iff (rst)
        run |=> cnt == $past(cnt) + CW'(1));

    p_ignore_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (run && (wr_lo || wr_hi)) |=> cnt[DW-1:0] == $past(cnt[DW-1:0]) + DW'(1));

    p_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (run && (&cnt[DW-1:0])) |=> cnt[CW-1:DW] == $past(cnt[CW-1:DW]) + DW'(1));

endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2*DW-1:0] cnt,
    input  logic            cmp_en,
    input  logic            auto_inc,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic            wr_step,
    input  logic            wr_stat,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cmp,
    output logic [DW-1:0]   step,
    output logic            flag
);
    localparam int CW = 2 * DW;

    logic match;
    logic clr_req;

    assign match   = cmp_en && (cnt == cmp);
    assign clr_req = wr_stat && wdata[0];

    // A software write to either compare half wins over the auto-increment.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cmp[DW-1:0]  <= wdata;
            if (wr_hi) cmp[CW-1:DW] <= wdata;
        end else if (match && auto_inc) begin
            cmp <= cmp + {{DW{1'b0}}, step};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          step <= '0;
        else if (wr_step) step <= wdata;
    end

    // A match in the same cycle as a clear keeps the flag set.
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (match)   flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    p_set_r6: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag && !match) |=> !flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    p_autoinc_r8: assert property (@(posedge clk) disable iff (rst)
        (match && auto_inc && !wr_lo && !wr_hi) |=> cmp == $past(cmp) + CW'($past(step)));

endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
    import gtmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o
);
    localparam int CW = 2 * DW;

    wr_strobe_t      wr;
    ctrl_t           ctrl_q;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cmp;
    logic [DW-1:0]   step;
    logic            flag;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr.ctrl) ctrl_q <= ctrl_from_word(bus_wdata[CTRL_W-1:0]);
    end

    assign irq_o = flag && ctrl_q.irq_en;

    gtmr_regif #(.ADDR_W(ADDR_W), .DW(DW)) u_regif (
        .we    (bus_we),
        .addr  (bus_addr),
        .cnt   (cnt),
        .ctrl  (ctrl_q),
        .flag  (flag),
        .cmp   (cmp),
        .step  (step),
        .wr    (wr),
        .rdata (bus_rdata)
    );

    gtmr_counter #(.DW(DW)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.run),
        .wr_lo (wr.cnt_lo),
        .wr_hi (wr.cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    gtmr_compare #(.DW(DW)) u_compare (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .cmp_en   (ctrl_q.cmp_en),
        .auto_inc (ctrl_q.auto_inc),
        .wr_lo    (wr.cmp_lo),
        .wr_hi    (wr.cmp_hi),
        .wr_step  (wr.step),
        .wr_stat  (wr.stat),
        .wdata    (bus_wdata),
        .cmp      (cmp),
        .step     (step),
        .flag     (flag)
    );

    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.irq_en) |-> !irq_o);

endmodule

// File: tb/gtmr_top_tb_top.sv
module gtmr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gtmr_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // {write, offset, data, expected read}; one row per clock.
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h08, 32'h0000_0000, 32'h0},           // stop
        {1'b1, 8'h00, 32'hFFFF_FFF0, 32'h0},           // R4 load low while stopped
        {1'b1, 8'h04, 32'h0000_0001, 32'h0},           // R4 load high
        {1'b0, 8'h00, 32'h0,         32'hFFFF_FFF0},   // R4 / R3 hold
        {1'b0, 8'h04, 32'h0,         32'h0000_0001},   // R4
        {1'b1, 8'h10, 32'hA5A5_A5A5, 32'h0},           // R2
        {1'b1, 8'h14, 32'h5A5A_5A5A, 32'h0},
        {1'b1, 8'h18, 32'h0000_0010, 32'h0},
        {1'b0, 8'h10, 32'h0,         32'hA5A5_A5A5},   // R2
        {1'b0, 8'h14, 32'h0,         32'h5A5A_5A5A},   // R2
        {1'b0, 8'h18, 32'h0,         32'h0000_0010},   // R2
        {1'b1, 8'h08, 32'hFFFF_FFF0, 32'h0},           // R2 upper control bits dropped
        {1'b0, 8'h08, 32'h0,         32'h0},           // R2
        {1'b1, 8'h08, 32'h0000_000D, 32'h0},           // run, irq, auto-inc, no compare
        {1'b0, 8'h08, 32'h0,         32'h0000_000D},   // R2 count = ..F0
        {1'b1, 8'h00, 32'h0000_0000, 32'h0},           // R4 ignored write, count = ..F1
        {1'b0, 8'h04, 32'h0,         32'h0000_0001},   // R4 count = ..F2
        {1'b0, 8'h00, 32'h0,         32'hFFFF_FFF3},   // R3 / R4
        {1'b0, 8'h1C, 32'h0,         32'h0},           // R2 unmapped
        {1'b0, 8'h0C, 32'h0,         32'h0}            // R6 compare disabled
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge clk);
        bus_we = w;
        bus_addr = a;
        bus_wdata = d;
        #1 r = bus_rdata;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic        w;
        logic [7:0]  a;
        logic [31:0] d, e;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int o = 0; o <= 'h18; o += 4) begin
            step(1'b0, 8'(o), 32'h0, r);
            chk("R1", r, 32'h0);
        end
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            {w, a, d, e} = VEC[i];
            step(w, a, d, r);
            if (!w) chk($sformatf("table row %0d", i), r, e);
        end

        // R5 carry and R3 count/hold
        step(1'b1, 8'h08, 32'h0, r);
        step(1'b1, 8'h00, 32'hFFFF_FFFE, r);
        step(1'b1, 8'h04, 32'h0000_0005, r);
        step(1'b1, 8'h08, 32'h1, r);
        step(1'b0, 8'h04, 32'h0, r); chk("R5 hi before wrap", r, 32'h5);
        step(1'b0, 8'h00, 32'h0, r); chk("R5 lo all ones", r, 32'hFFFF_FFFF);
        step(1'b0, 8'h04, 32'h0, r); chk("R5 hi after wrap", r, 32'h6);
        step(1'b0, 8'h00, 32'h0, r); chk("R5 lo after wrap", r, 32'h1);
        step(1'b0, 8'h00, 32'h0, r); chk("R3 count", r, 32'h2);
        step(1'b1, 8'h08, 32'h0, r);
        step(1'b0, 8'h00, 32'h0, r); chk("R3 last increment", r, 32'h4);
        step(1'b0, 8'h00, 32'h0, r); chk("R3 hold", r, 32'h4);

        // R6 / R7 / R9 match, sticky flag, interrupt
        step(1'b1, 8'h00, 32'h0, r);
        step(1'b1, 8'h04, 32'h0, r);
        step(1'b1, 8'h10, 32'd10, r);
        step(1'b1, 8'h14, 32'h0, r);
        step(1'b1, 8'h0C, 32'h1, r);
        step(1'b1, 8'h08, 32'h7, r);
        for (int j = 1; j <= 12; j++) begin
            step(1'b0, 8'h0C, 32'h0, r);
            chk("R6 event", r, (j >= 12) ? 32'h1 : 32'h0);
            chk("R9 irq", {31'b0, irq_o}, (j >= 12) ? 32'h1 : 32'h0);
        end
        step(1'b1, 8'h0C, 32'h0, r);
        step(1'b0, 8'h0C, 32'h0, r); chk("R7 write zero keeps flag", r, 32'h1);
        step(1'b1, 8'h08, 32'h3, r);
        step(1'b0, 8'h0C, 32'h0, r); chk("R7 flag held", r, 32'h1);
        chk("R9 irq masked", {31'b0, irq_o}, 32'h0);
        step(1'b1, 8'h0C, 32'h1, r);
        step(1'b0, 8'h0C, 32'h0, r); chk("R7 clear", r, 32'h0);

        // R6 compare disabled
        step(1'b1, 8'h08, 32'h0, r);
        step(1'b1, 8'h00, 32'h0, r);
        step(1'b1, 8'h04, 32'h0, r);
        step(1'b1, 8'h10, 32'h3, r);
        step(1'b1, 8'h0C, 32'h1, r);
        step(1'b1, 8'h08, 32'h1, r);
        for (int j = 1; j <= 8; j++) begin
            step(1'b0, 8'h0C, 32'h0, r);
            chk("R6 no event when disabled", r, 32'h0);
        end

        // R8 periodic auto-increment
        step(1'b1, 8'h08, 32'h0, r);
        step(1'b1, 8'h00, 32'h0, r);
        step(1'b1, 8'h04, 32'h0, r);
        step(1'b1, 8'h10, 32'h5, r);
        step(1'b1, 8'h14, 32'h0, r);
        step(1'b1, 8'h18, 32'h4, r);
        step(1'b1, 8'h0C, 32'h1, r);
        step(1'b1, 8'h08, 32'hB, r);
        for (int j = 1; j <= 12; j++) begin
            step(1'b0, 8'h10, 32'h0, r);
            chk("R8 compare advance", r, (j <= 6) ? 32'd5 : ((j <= 10) ? 32'd9 : 32'd13));
        end

        // R8 carry into compare high half
        step(1'b1, 8'h08, 32'h0, r);
        step(1'b1, 8'h00, 32'hFFFF_FFFE, r);
        step(1'b1, 8'h04, 32'h0, r);
        step(1'b1, 8'h10, 32'hFFFF_FFFE, r);
        step(1'b1, 8'h14, 32'h0, r);
        step(1'b1, 8'h18, 32'h3, r);
        step(1'b1, 8'h08, 32'hB, r);
        step(1'b0, 8'h14, 32'h0, r); chk("R8 hi before match", r, 32'h0);
        step(1'b0, 8'h14, 32'h0, r); chk("R8 hi carry", r, 32'h1);
        step(1'b0, 8'h10, 32'h0, r); chk("R8 lo after carry", r, 32'h1);
        step(1'b1, 8'h08, 32'h0, r);
        step(1'b0, 8'h00, 32'h0, r);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule